// File: doc/BRIEF.md
# Debug Monitor Command Engine

This block is a hardware command interpreter that lets a host computer inspect and load target memory over a byte-wide link. Bytes arrive from the host as single-cycle strobes on a receive interface. Replies leave as single-cycle strobes on a transmit interface. The engine stays silent until the host sends a two-byte wake pattern. It answers that pattern with an acknowledge byte, and from then on it accepts one command byte at a time. After each command it returns to waiting for the next command, without needing a new wake pattern.

The commands cover resynchronisation, echo, block download into memory, block upload from memory, two commands that are only acknowledged, and no-ops. Downloads and uploads carry a header of a 24-bit start address and a 16-bit byte count, each sent low byte first. The engine drives a simple synchronous memory port. The address and write data come from the engine, and the read data returns one clock after the address. A small reserved window at the bottom of the address space cannot be written by a download. Each byte aimed at that window is dropped and reported on a one-cycle error output.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset, txValid, errPulse and memWe are low, and the engine waits for the wake pattern.
- R2: Until the engine has received 0x55 followed directly by 0xAA, every received byte produces no transmit and no memory access. Extra 0x55 bytes before the 0xAA are tolerated. Any other byte restarts the search for the pattern. When the pattern completes, the engine transmits 0xCC.
- R3: Command byte 0x00 (resync) makes the engine transmit 0x00.
- R4: Command byte 0x01 (echo) makes the engine transmit the next received byte back unchanged.
- R5: Command byte 0x02 (download) reads five header bytes: address bits 7:0, 15:8 and 23:16, then count bits 7:0 and 15:8. It then writes each of the next count received bytes to ascending addresses, starting at the header address.
- R6: A download byte whose address lies in 0x000000..0x000005 is not written, and errPulse is high for exactly one cycle for that byte. The remaining bytes of the block are still written.
- R7: Command byte 0x03 (upload) uses the same header and transmits count memory bytes in ascending address order. Reads of the reserved window are allowed.
- R8: A download or upload header with a count of zero ends the command with no memory write and no transmit. The engine then accepts the next command.
- R9: Command bytes 0x04 and 0x05 each transmit one 0xCC. Command bytes 0x06 and 0x07 transmit nothing.
- R10: A command byte above 0x07 transmits nothing and raises errPulse for one cycle. The engine remains ready for commands.
- R11: Every reply byte appears on txValid/txData for one cycle, one clock after the byte or memory read that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received byte strobe |
| rxData | input | 8 | Received byte |
| txValid | output | 1 | Transmit byte strobe |
| txData | output | 8 | Transmit byte |
| memAddr | output | 24 | Memory address (read and write) |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 8 | Memory read data, valid one clock after memAddr |
| errPulse | output | 1 | One-cycle pulse on a rejected write or an unknown command |

## Verification
The bench sends broken wake patterns, and it sends commands before the session opens. An engine that opened too early would reply to those commands. The bench downloads a block that straddles the top of the reserved window. A wrong bound would either write address 5 or drop address 6, and a design that aborted the block would lose the later bytes. The bench then uploads across freshly written data. An off-by-one between the read address and the transmit would shift every reply byte by one. It also sends zero-count headers and unknown codes. Either could leave the engine stuck in a data phase, or could pulse the error output on the wrong cycles.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

  localparam logic [7:0] WAKE_FIRST  = 8'h55;
  localparam logic [7:0] WAKE_SECOND = 8'hAA;
  localparam logic [7:0] ACK_BYTE    = 8'hCC;
  localparam logic [7:0] SYNC_BYTE   = 8'h00;

  typedef enum logic [3:0] {
    S_WAKE0, S_WAKE1, S_CMD, S_ECHO, S_HDR, S_HDRCHK, S_DLOAD, S_UPRD, S_UPTX
  } engState_t;

  typedef enum logic [1:0] {TX_ACK, TX_SYNC, TX_RX, TX_MEM} txSrc_t;

  typedef struct packed {
    logic   hdrShift;
    logic   incAddr;
    logic   decCnt;
    logic   txLoad;
    txSrc_t txSel;
  } dpStrobe_t;

endpackage

// File: rtl/dbg_cmd_datapath.sv
module dbg_cmd_datapath
  import dbg_cmd_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int CNT_W    = 16,
  parameter int RESV_TOP = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [7:0]        rxData,
  input  logic [7:0]        memRdata,
  input  logic              memWe,
  output logic [ADDR_W-1:0] addr,
  output logic              cntZero,
  output logic              cntLast,
  output logic              inResv,
  output logic              txValid,
  output logic [7:0]        txData
);

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  cntQ;

  // Header bytes enter at the top of {count,address} and move down, so the
  // first (least significant address) byte lands in addrQ[7:0].
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      cntQ  <= '0;
    end else if (strb.hdrShift) begin
      {cntQ, addrQ} <= {rxData, cntQ, addrQ[ADDR_W-1:8]};
    end else begin
      if (strb.incAddr) addrQ <= addrQ + 1'b1;
      if (strb.decCnt)  cntQ  <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= strb.txLoad;
      if (strb.txLoad) begin
        case (strb.txSel)
          TX_ACK:  txData <= ACK_BYTE;
          TX_SYNC: txData <= SYNC_BYTE;
          TX_RX:   txData <= rxData;
          default: txData <= memRdata;
        endcase
      end
    end
  end

  assign addr    = addrQ;
  assign cntZero = (cntQ == '0);
  assign cntLast = (cntQ == CNT_W'(1));
  assign inResv  = (addrQ <= ADDR_W'(RESV_TOP));

  p_no_resv_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (addrQ > ADDR_W'(RESV_TOP)));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decCnt && !strb.hdrShift) |=> (cntQ == CNT_W'($past(cntQ) - 1'b1)));

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incAddr && !strb.hdrShift) |=> (addrQ == ADDR_W'($past(addrQ) + 1'b1)));

  p_tx_one_cycle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.txLoad |=> !txValid);

endmodule

// File: rtl/dbg_cmd_control.sv
module dbg_cmd_control
  import dbg_cmd_pkg::*;
#(
  parameter int HDR_BYTES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       cntZero,
  input  logic       cntLast,
  input  logic       inResv,
  output dpStrobe_t  strb,
  output logic       memWe,
  output logic       errPulse
);

  localparam int HCW = $clog2(HDR_BYTES + 1);

  engState_t      state, nxt;
  logic [HCW-1:0] hdrCnt;
  logic           isUpload;
  logic           errNext;

  always_comb begin
    nxt     = state;
    strb    = '0;
    memWe   = 1'b0;
    errNext = 1'b0;
    case (state)
      S_WAKE0: if (rxValid && rxData == WAKE_FIRST) nxt = S_WAKE1;
      S_WAKE1: if (rxValid) begin
        if (rxData == WAKE_SECOND) begin
          nxt          = S_CMD;
          strb.txLoad  = 1'b1;
          strb.txSel   = TX_ACK;
        end else if (rxData != WAKE_FIRST) begin
          nxt = S_WAKE0;
        end
      end
      S_CMD: if (rxValid) begin
        case (rxData)
          8'h00: begin strb.txLoad = 1'b1; strb.txSel = TX_SYNC; end
          8'h01: nxt = S_ECHO;
          8'h02, 8'h03: nxt = S_HDR;
          8'h04, 8'h05: begin strb.txLoad = 1'b1; strb.txSel = TX_ACK; end
          8'h06, 8'h07: ;
          default: errNext = 1'b1;
        endcase
      end
      S_ECHO: if (rxValid) begin
        strb.txLoad = 1'b1;
        strb.txSel  = TX_RX;
        nxt         = S_CMD;
      end
      S_HDR: if (rxValid) begin
        strb.hdrShift = 1'b1;
        if (hdrCnt == HCW'(HDR_BYTES - 1)) nxt = S_HDRCHK;
      end
      S_HDRCHK: begin
        if (cntZero)       nxt = S_CMD;
        else if (isUpload) nxt = S_UPRD;
        else               nxt = S_DLOAD;
      end
      S_DLOAD: if (rxValid) begin
        strb.incAddr = 1'b1;
        strb.decCnt  = 1'b1;
        if (inResv) errNext = 1'b1;
        else        memWe   = 1'b1;
        if (cntLast) nxt = S_CMD;
      end
      S_UPRD: nxt = S_UPTX;
      S_UPTX: begin
        strb.txLoad  = 1'b1;
        strb.txSel   = TX_MEM;
        strb.incAddr = 1'b1;
        strb.decCnt  = 1'b1;
        nxt          = cntLast ? S_CMD : S_UPRD;
      end
      default: nxt = S_WAKE0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_WAKE0;
      hdrCnt   <= '0;
      isUpload <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      state    <= nxt;
      errPulse <= errNext;
      if (state == S_CMD) begin
        hdrCnt <= '0;
        if (rxValid) isUpload <= (rxData == 8'h03);
      end else if (strb.hdrShift) begin
        hdrCnt <= hdrCnt + 1'b1;
      end
    end
  end

  p_closed_no_mem_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAKE0 || state == S_WAKE1) |-> (!memWe && !strb.incAddr));

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HDRCHK && cntZero) |=> (state == S_CMD));

  p_unknown_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CMD && rxValid && rxData > 8'h07) |=> (errPulse && state == S_CMD));

  p_cmd_wait_no_tx_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CMD && rxValid && (rxData == 8'h06 || rxData == 8'h07)) |-> !strb.txLoad);

endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
  import dbg_cmd_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int CNT_W    = 16,
  parameter int RESV_TOP = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  input  logic [7:0]        memRdata,
  output logic              errPulse
);

  localparam int HDR_BYTES = (ADDR_W + CNT_W) / 8;

  dpStrobe_t strb;
  logic      cntZero, cntLast, inResv;

  dbg_cmd_control #(.HDR_BYTES(HDR_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .cntZero(cntZero), .cntLast(cntLast), .inResv(inResv),
    .strb(strb), .memWe(memWe), .errPulse(errPulse)
  );

  dbg_cmd_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESV_TOP(RESV_TOP)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rxData(rxData), .memRdata(memRdata),
    .memWe(memWe), .addr(memAddr), .cntZero(cntZero), .cntLast(cntLast),
    .inResv(inResv), .txValid(txValid), .txData(txData)
  );

  assign memWdata = rxData;

endmodule

// File: tb/dbg_cmd_engine_tb.sv
`timescale 1ns/1ps
module dbg_cmd_engine_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        txValid, memWe, errPulse;
  logic [7:0]  txData, memWdata;
  logic [7:0]  memRdata = '0;
  logic [23:0] memAddr;

  int checks = 0;
  int errors = 0;
  int errSeen = 0;
  int expErr = 0;
  bit finished = 0;

  logic [7:0] mem    [1024];
  logic [7:0] refMem [1024];
  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2.5 clk = ~clk;

  dbg_cmd_engine dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .txValid(txValid), .txData(txData), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata), .errPulse(errPulse)
  );

  // Target memory: synchronous read, one clock of latency.
  always @(posedge clk) begin
    if (memWe) mem[memAddr[9:0]] <= memWdata;
    memRdata <= mem[memAddr[9:0]];
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the reference queue.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (txValid) begin
        if (expQ.size() == 0) check(0, "R2/R10 unexpected transmit", txData, 0);
        else begin
          string t;
          logic [7:0] e;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(txData == e, t, txData, e);
        end
      end
      if (errPulse) errSeen++;
      if (memWe && memAddr <= 24'd5) check(0, "R6 reserved write", memAddr, 6);
    end
  end

  task automatic expectTx(logic [7:0] b, string tag);
    expQ.push_back(b);
    tagQ.push_back(tag);
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxData = b;
    @(negedge clk); rxValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendHeader(logic [23:0] a, logic [15:0] n);
    sendByte(a[7:0]); sendByte(a[15:8]); sendByte(a[23:16]);
    sendByte(n[7:0]); sendByte(n[15:8]);
  endtask

  task automatic download(logic [23:0] a, logic [15:0] n, logic [7:0] seed);
    sendByte(8'h02);
    sendHeader(a, n);
    idle(2);
    for (int i = 0; i < int'(n); i++) begin
      logic [7:0] b;
      logic [23:0] ad;
      b  = seed + 8'(i * 7);
      ad = a + 24'(i);
      if (ad <= 24'd5) expErr++;
      else refMem[ad[9:0]] = b;
      sendByte(b);
    end
  endtask

  task automatic upload(logic [23:0] a, logic [15:0] n);
    sendByte(8'h03);
    sendHeader(a, n);
    for (int i = 0; i < int'(n); i++) begin
      logic [23:0] ad;
      ad = a + 24'(i);
      expectTx(refMem[ad[9:0]], "R7 upload byte");
    end
    idle(2 * int'(n) + 6);
  endtask

  task automatic drained(string tag);
    idle(3);
    check(expQ.size() == 0, tag, expQ.size(), 0);
    check(errSeen == expErr, {tag, " error pulses"}, errSeen, expErr);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]    = 8'(i) ^ 8'h3C;
      refMem[i] = 8'(i) ^ 8'h3C;
    end
    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!txValid, "R1 txValid after reset", txValid, 0);
    check(!errPulse, "R1 errPulse after reset", errPulse, 0);
    check(!memWe, "R1 memWe after reset", memWe, 0);

    // R2 commands before wake, broken pattern, then 55 55 AA
    sendByte(8'h00); sendByte(8'h01); sendByte(8'hAA);
    sendByte(8'h55); sendByte(8'h12); sendByte(8'hAA);
    drained("R2 closed session silent");
    expectTx(8'hCC, "R2 wake acknowledge");
    sendByte(8'h55); sendByte(8'h55); sendByte(8'hAA);
    drained("R2 wake");

    // R3 resync
    expectTx(8'h00, "R3 sync byte");
    sendByte(8'h00);
    drained("R3");

    // R4 echo, R11 timing is covered by the per-clock compare
    expectTx(8'h5A, "R4 echo 5A");
    sendByte(8'h01); sendByte(8'h5A);
    expectTx(8'hCC, "R4 echo CC");
    sendByte(8'h01); sendByte(8'hCC);
    drained("R4");

    // R5 download, then R7 upload across it
    download(24'h000100, 16'd4, 8'hA1);
    drained("R5 download");
    upload(24'h0000FE, 16'd6);
    drained("R7 upload");

    // R6 block straddling reserved window
    download(24'h000003, 16'd5, 8'h40);
    drained("R6 reserved window");
    upload(24'h000000, 16'd8);
    drained("R6/R7 readback");

    // R8 zero-count headers
    download(24'h000200, 16'd0, 8'h00);
    upload(24'h000200, 16'd0);
    expectTx(8'h00, "R8 ready after zero count");
    sendByte(8'h00);
    drained("R8");

    // R9 acknowledge-only and no-op codes
    expectTx(8'hCC, "R9 code 04");
    sendByte(8'h04);
    expectTx(8'hCC, "R9 code 05");
    sendByte(8'h05);
    sendByte(8'h06); sendByte(8'h07);
    drained("R9");

    // R10 unknown codes
    sendByte(8'h08); expErr++;
    sendByte(8'hFF); expErr++;
    expectTx(8'hCC, "R10 still in command wait");
    sendByte(8'h04);
    drained("R10");

    // R5/R6 final memory image
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== refMem[i]) bad++;
      check(bad == 0, "R5/R6 memory image mismatches", bad, 0);
    end
    summary();
  end

endmodule